// File: doc/BRIEF.md
# SPI-Mode SD Card Byte Host

This block is a memory-mapped slave that lets a processor exchange single bytes with an SD card running in SPI mode. The processor side is a simple command/address/data port: a command of read or write is sampled together with a byte offset. Every access is acknowledged with a data-valid response one cycle later, and read data is returned in the same cycle as that response. The card side has four wires: serial clock, chip select, data out to the card and data in from the card. A write-protect signal from the card is not used.

Software first sets the divisor and drives chip select low. It then writes a byte to the data register, which starts one full-duplex exchange. The block shifts that byte out most-significant bit first and captures the card's reply into the receive register. Software polls the busy flag until it clears and then reads the received byte. The serial clock is produced by dividing the system clock and runs only while an exchange is in progress.

Top module: `sd_spi_host`

## Requirements
- R1: Every read (command 2) or write (command 1), including one to an unmapped offset or a write to a read-only offset, gives response 1 (data valid) on bus_resp_o in the following cycle. An idle command (0) gives response 0.
- R2: Reads are decoded as follows, with narrower values zero-extended to 32 bits. Offset 0x0 returns the received byte in bits 7:0. Offset 0x8 returns the busy flag in bit 0. Offsets 0x4, 0xC and any unmapped offset return zero. A write to offset 0x8 has no effect.
- R3: A write to offset 0x4 sets cs_o to write-data bit 0. After reset cs_o is 1.
- R4: While busy, each serial clock phase lasts exactly the divisor's number of system clocks, so the period is 2 × divisor. A write to offset 0xC (bits 15:0) sets the divisor. The reset divisor is ceil(SYS_CLK_HZ / (2 × SLOW_SCK_HZ)), which is 100 at the defaults.
- R5: When no exchange is active, sck_o is held low and mosi_o is 0.
- R6: A write to offset 0x0 while idle does all of the following at once: it loads bits 7:0 as the transmit byte, clears the receive byte to zero, sets busy, and restarts the divider. The serial clock starts low.
- R7: mosi_o presents the transmit byte most-significant bit first. The bit changes at each falling edge of sck_o, so it is stable at each rising edge.
- R8: On each falling edge of sck_o, miso_i is stored into the receive byte at the current bit position, starting at bit 7.
- R9: An exchange consists of exactly 8 serial clock periods. Busy clears on the eighth falling edge.
- R10: A write to offset 0x0 while busy is acknowledged but changes neither the byte being sent nor the exchange in progress.
- R11: After reset the bus response is 0, read data is 0, sck_o and mosi_o are 0, and the receive byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_cmd_i | input | 3 | Bus command: 0 idle, 1 write, 2 read |
| bus_addr_i | input | ADDR_W (8) | Byte offset of the register accessed |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_rdata_o | output | DATA_W (32) | Read data, valid with the response |
| bus_resp_o | output | 2 | Response: 0 none, 1 data valid |
| sck_o | output | 1 | Divided serial clock to the card |
| cs_o | output | 1 | Chip select to the card, active low |
| mosi_o | output | 1 | Serial data to the card |
| miso_i | input | 1 | Serial data from the card |

## Verification
A wrong divider count shows up at once on sck_o as a phase that is too long or too short, and it shifts every later edge of the exchange. A wrong bit pointer shows up as a permuted or shortened byte. It appears at the card's capture of mosi_o within one serial period, and in the received byte once busy clears. A busy flag that sticks, or clears early, is seen by the next status poll and as extra or missing clock edges. A decode fault appears on the very next bus response or read data.

// File: rtl/sd_spi_pkg.sv
package sd_spi_pkg;
  typedef enum logic [2:0] {
    CMD_IDLE  = 3'd0,
    CMD_WRITE = 3'd1,
    CMD_READ  = 3'd2
  } bus_cmd_e;

  typedef enum logic [1:0] {
    RESP_NONE = 2'd0,
    RESP_DVA  = 2'd1
  } bus_resp_e;

  localparam int unsigned OFS_DATA = 32'h0;
  localparam int unsigned OFS_CSEL = 32'h4;
  localparam int unsigned OFS_STAT = 32'h8;
  localparam int unsigned OFS_DIV  = 32'hC;
  localparam int unsigned BYTE_W   = 8;
endpackage

// File: rtl/sd_spi_regs.sv
module sd_spi_regs
  import sd_spi_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned DIV_RST = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        bus_cmd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [1:0]        bus_resp_o,
  input  logic              busy_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  output logic              start_o,
  output logic [BYTE_W-1:0] start_byte_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              cs_o
);
  logic acc_wr, acc_rd;
  logic sel_data, sel_csel, sel_stat, sel_div;
  logic [DATA_W-1:0] rd_val, rdata_q;
  logic [DIV_W-1:0]  div_q;
  logic              cs_q;
  bus_resp_e         resp_q;
  logic              wdata_unused;

  assign acc_wr   = bus_cmd_i == CMD_WRITE;
  assign acc_rd   = bus_cmd_i == CMD_READ;
  assign sel_data = bus_addr_i == ADDR_W'(OFS_DATA);
  assign sel_csel = bus_addr_i == ADDR_W'(OFS_CSEL);
  assign sel_stat = bus_addr_i == ADDR_W'(OFS_STAT);
  assign sel_div  = bus_addr_i == ADDR_W'(OFS_DIV);

  // transmit writes while busy are dropped
  assign start_o      = acc_wr & sel_data & ~busy_i;
  assign start_byte_o = bus_wdata_i[BYTE_W-1:0];
  assign wdata_unused = ^bus_wdata_i[DATA_W-1:DIV_W];

  always_comb begin
    rd_val = '0;
    if (sel_data)      rd_val[BYTE_W-1:0] = rx_byte_i;
    else if (sel_stat) rd_val[0]          = busy_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q    <= 1'b1;
      div_q   <= DIV_W'(DIV_RST);
      resp_q  <= RESP_NONE;
      rdata_q <= '0;
    end else begin
      if (acc_wr && sel_csel) cs_q  <= bus_wdata_i[0];
      if (acc_wr && sel_div)  div_q <= bus_wdata_i[DIV_W-1:0];
      resp_q  <= (acc_wr || acc_rd) ? RESP_DVA : RESP_NONE;
      rdata_q <= acc_rd ? rd_val : '0;
    end
  end

  assign bus_rdata_o = rdata_q;
  assign bus_resp_o  = resp_q;
  assign div_o       = div_q;
  assign cs_o        = cs_q;

  a_r1_access_acked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_wr || acc_rd) |=> bus_resp_o == RESP_DVA);
  a_r1_idle_no_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cmd_i == CMD_IDLE) |=> bus_resp_o == RESP_NONE);
  a_r2_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_rd && !sel_data && !sel_stat) |=> bus_rdata_o == '0);
  a_r3_cs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_wr && sel_csel) |=> cs_o == $past(bus_wdata_i[0]));
endmodule

// File: rtl/sd_spi_clkgen.sv
module sd_spi_clkgen #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sck_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             sck_q;
  logic             reload;

  // divisor 0 behaves like 1
  assign reload = cnt_q <= DIV_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= div_i;
      sck_q <= 1'b0;
    end else if (!run_i) begin
      sck_q <= 1'b0;
    end else if (reload) begin
      cnt_q <= div_i;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q - DIV_W'(1);
    end
  end

  assign sck_o  = sck_q;
  assign fall_o = run_i & sck_q & reload;

  a_r4_toggle_on_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && reload) |=> sck_q != $past(sck_q));
  a_r4_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && !reload) |=> $stable(sck_q));
  a_r5_stop_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> !sck_q);
endmodule

// File: rtl/sd_spi_shifter.sv
module sd_spi_shifter
  import sd_spi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] start_byte_i,
  input  logic              fall_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              mosi_o,
  output logic [BYTE_W-1:0] rx_byte_o
);
  localparam int unsigned PTR_W = $clog2(BYTE_W) + 1;

  logic [PTR_W-1:0]  ptr_q;
  logic [BYTE_W-1:0] tx_q, rx_q;
  logic              busy_q;
  logic [PTR_W-2:0]  bit_idx;

  assign bit_idx = (PTR_W-1)'(ptr_q - PTR_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      tx_q   <= start_byte_i;
      rx_q   <= '0;
      ptr_q  <= PTR_W'(BYTE_W);
      busy_q <= 1'b1;
    end else if (busy_q && fall_i) begin
      rx_q[bit_idx] <= miso_i;
      ptr_q         <= ptr_q - PTR_W'(1);
      if (ptr_q == PTR_W'(1)) busy_q <= 1'b0;
    end
  end

  assign mosi_o    = (ptr_q != '0) & tx_q[bit_idx];
  assign busy_o    = busy_q;
  assign rx_byte_o = rx_q;

  a_r6_start_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_q && rx_q == '0 && ptr_q == PTR_W'(BYTE_W));
  a_r9_ptr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (ptr_q != '0 && ptr_q <= PTR_W'(BYTE_W)));
  a_r9_last_fall_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && fall_i && ptr_q == PTR_W'(1)) |=> !busy_q);
  a_r10_tx_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(tx_q));
endmodule

// File: rtl/sd_spi_host.sv
module sd_spi_host
  import sd_spi_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ  = 80_000_000,
  parameter int unsigned SLOW_SCK_HZ = 400_000,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned DIV_W       = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        bus_cmd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [1:0]        bus_resp_o,
  output logic              sck_o,
  output logic              cs_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  localparam int unsigned DIV_RST = (SYS_CLK_HZ + 2*SLOW_SCK_HZ - 1) / (2*SLOW_SCK_HZ);

  logic              start, busy, fall;
  logic [BYTE_W-1:0] start_byte, rx_byte;
  logic [DIV_W-1:0]  div;

  sd_spi_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DIV_W  (DIV_W),
    .DIV_RST(DIV_RST)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_cmd_i   (bus_cmd_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .bus_resp_o  (bus_resp_o),
    .busy_i      (busy),
    .rx_byte_i   (rx_byte),
    .start_o     (start),
    .start_byte_o(start_byte),
    .div_o       (div),
    .cs_o        (cs_o)
  );

  sd_spi_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy),
    .load_i(start),
    .div_i (div),
    .sck_o (sck_o),
    .fall_o(fall)
  );

  sd_spi_shifter u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .start_byte_i(start_byte),
    .fall_i      (fall),
    .miso_i      (miso_i),
    .busy_o      (busy),
    .mosi_o      (mosi_o),
    .rx_byte_o   (rx_byte)
  );

  a_r5_idle_sck_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !sck_o);
  a_r5_idle_mosi_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mosi_o);
  a_r10_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !fall) |=> busy);
endmodule

// File: tb/sd_spi_host_test.sv
module sd_spi_host_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  bus_cmd = 3'd0;
  logic [7:0]  bus_addr = 8'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic [1:0]  bus_resp;
  logic        sck, cs, mosi, miso;

  int tests = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  sd_spi_host uut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_cmd_i(bus_cmd), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .bus_resp_o(bus_resp),
    .sck_o(sck), .cs_o(cs), .mosi_o(mosi), .miso_i(miso)
  );

  // sck monitor, sampled away from the active edge
  int n_rise, hi_cyc, rise_a, rise_b;
  logic sck_prev = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (sck && !sck_prev) begin rise_a = rise_b; rise_b = cyc; n_rise++; end
    if (sck) hi_cyc++;
    sck_prev = sck;
  end

  // loopback card: shifts card_out MSB first, records mosi at rising sck
  logic [7:0] card_out = 8'd0, card_in = 8'd0;
  int card_idx = -1;
  assign miso = (card_idx >= 0) ? card_out[card_idx[2:0]] : 1'b0;
  always @(posedge sck) card_in = {card_in[6:0], mosi};
  always @(negedge sck) begin #1; card_idx--; end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus(input logic [2:0] cmd, input logic [7:0] addr, input logic [31:0] wd,
                     output logic [31:0] rd, output logic [1:0] rs);
    @(negedge clk);
    bus_cmd = cmd; bus_addr = addr; bus_wdata = wd;
    @(negedge clk);
    bus_cmd = 3'd0;
    rd = bus_rdata; rs = bus_resp;
  endtask

  function automatic int exp_hi(input int div);
    return 8 * ((div == 0) ? 1 : div);
  endfunction

  task automatic xfer(input logic [7:0] tx, input logic [7:0] cb, input int div,
                      input bit rx_clear_chk, input bit intrude);
    logic [31:0] rd; logic [1:0] rs; int polls;
    card_out = cb; card_idx = 7; card_in = 8'd0;
    n_rise = 0; hi_cyc = 0; rise_a = 0; rise_b = 0;
    bus(3'd1, 8'h0, {24'd0, tx}, rd, rs);
    check(rs == 2'd1, "R1 write ack", rs, 1);
    bus(3'd2, 8'h8, 0, rd, rs);
    check(rd == 32'd1, "R9 busy after start", rd, 1);
    if (rx_clear_chk) begin
      bus(3'd2, 8'h0, 0, rd, rs);
      check(rd == 32'd0, "R6 rx cleared at start", rd, 0);
    end
    if (intrude) begin
      bus(3'd1, 8'h0, {24'd0, ~tx}, rd, rs);
      check(rs == 2'd1, "R10 busy write acked", rs, 1);
    end
    polls = 0;
    do begin
      bus(3'd2, 8'h8, 0, rd, rs);
      polls++;
    end while (rd[0] && polls < 5000);
    bus(3'd2, 8'h0, 0, rd, rs);
    check(rd == {24'd0, cb}, "R8 received byte", rd, cb);
    check(card_in == tx, intrude ? "R10 byte kept under busy write" : "R7 card got tx",
          card_in, tx);
    check(n_rise == 8, "R9 eight periods", n_rise, 8);
    check(hi_cyc == exp_hi(div), "R4 high phase total", hi_cyc, exp_hi(div));
    check(rise_b - rise_a == 2 * ((div == 0) ? 1 : div), "R4 period", rise_b - rise_a,
          2 * ((div == 0) ? 1 : div));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd; logic [1:0] rs; int d; logic [7:0] t, c;
    void'($urandom(32'h5D_C0DE));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(bus_resp == 2'd0, "R11 reset resp", bus_resp, 0);
    check(bus_rdata == 32'd0, "R11 reset rdata", bus_rdata, 0);
    check(!sck && !mosi, "R11 reset sck/mosi", {sck, mosi}, 0);
    check(cs == 1'b1, "R3 reset cs high", cs, 1);
    bus(3'd2, 8'h0, 0, rd, rs);
    check(rd == 0 && rs == 1, "R11 reset rx zero", rd, 0);
    bus(3'd2, 8'h8, 0, rd, rs);
    check(rd == 0 && rs == 1, "R2 idle busy flag", rd, 0);
    @(negedge clk);
    check(bus_resp == 2'd0, "R1 idle no resp", bus_resp, 0);

    bus(3'd1, 8'h4, 32'hFFFF_FFFE, rd, rs);
    check(cs == 1'b0 && rs == 1, "R3 cs low", cs, 0);
    bus(3'd2, 8'h4, 0, rd, rs);
    check(rd == 0 && rs == 1, "R2 write-only reads zero", rd, 0);
    bus(3'd2, 8'hC, 0, rd, rs);
    check(rd == 0 && rs == 1, "R2 divisor reads zero", rd, 0);
    bus(3'd2, 8'h10, 0, rd, rs);
    check(rd == 0 && rs == 1, "R1 unmapped read acked", {rd[29:0], rs}, 1);
    bus(3'd1, 8'h31, 32'hFF, rd, rs);
    check(rs == 1, "R1 unmapped write acked", rs, 1);
    bus(3'd1, 8'h8, 32'h1, rd, rs);
    check(rs == 1, "R1 read-only write acked", rs, 1);
    bus(3'd2, 8'h8, 0, rd, rs);
    check(rd == 0, "R2 read-only write no effect", rd, 0);
    check(!sck, "R5 sck idle after ro write", sck, 0);

    // reset divisor: half period 100
    xfer(8'hA5, 8'h3C, 100, 1'b1, 1'b0);

    begin
      bit low_ok = 1'b1;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (sck || mosi) low_ok = 1'b0;
      end
      check(low_ok, "R5 sck/mosi low while idle", low_ok, 1);
    end

    bus(3'd1, 8'hC, 32'hABCD_0004, rd, rs);
    xfer(8'h5A, 8'hC3, 4, 1'b1, 1'b0);
    bus(3'd1, 8'hC, 3, rd, rs);
    xfer(8'h96, 8'h81, 3, 1'b0, 1'b1);
    bus(3'd1, 8'hC, 1, rd, rs);
    xfer(8'h00, 8'hFF, 1, 1'b0, 1'b0);
    xfer(8'hFF, 8'h00, 1, 1'b0, 1'b0);
    bus(3'd1, 8'hC, 0, rd, rs);
    xfer(8'h81, 8'h7E, 0, 1'b0, 1'b0);

    for (int k = 0; k < 16; k++) begin
      d = 1 + ($urandom % 6);
      t = 8'($urandom);
      c = 8'($urandom);
      bus(3'd1, 8'hC, d, rd, rs);
      xfer(t, c, d, 1'b0, ($urandom % 4) == 0);
    end

    bus(3'd1, 8'h4, 32'h1, rd, rs);
    check(cs == 1'b1, "R3 cs high again", cs, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule